// File: doc/BRIEF.md
# Auto-Exposure Pixel Statistics Controller

This block looks at the luma stream of a camera pipeline one frame at a time. It counts the bright pixels, whose luma is above a programmable level, and the dark pixels, whose luma is below a second level. It also counts every pixel that falls inside the statistics window. The window is either the whole frame or, on request, the central quarter of the image: the middle half of the columns combined with the middle half of the rows.

At each frame-end strobe the block compares both counted fractions with two programmable target ratios. It then moves an exposure register or a gain register by one step, or leaves both alone. Exposure always moves first. Gain moves only when exposure is pinned at a limit or is held. A freeze input holds both registers. An exposure-hold input holds only exposure. A minimum-exposure select raises the lowest allowed exposure from one line to four lines. A stable flag reports that the last frame-end update changed nothing.

Top module: `ae_stats_ctrl`

## Requirements
- R1: After reset, `exposure` equals parameter EXP_INIT, `gain` is 0 and `ae_stable` is 0.
- R2: A windowed pixel counts as bright when `pix_luma > bright_lvl` and as dark when `pix_luma < dark_lvl`. A pixel whose luma equals a level is not counted in that population.
- R3: A `frame_start` pulse clears all counts, so a frame's decision depends only on pixels received after the most recent `frame_start`.
- R4: Let N be the number of windowed pixels, B the bright count and D the dark count. The direction is up when B·TGT_DEN < bright_tgt·N and D·TGT_DEN > black_tgt·N. It is down when B·TGT_DEN > bright_tgt·N and D·TGT_DEN < black_tgt·N. Otherwise it is hold. TGT_DEN defaults to 202, so 0x33 is about 25 % and 0x97 is about 75 %.
- R5: `exposure`, `gain` and `ae_stable` change only on the clock edge that samples `frame_end`, and they show the new values on the next cycle. Each frame moves by at most one step.
- R6: On up, exposure rises by 1 unless it is at its maximum (255). Only in that case does gain rise by 1, saturating at 2^GAIN_W−1. On down, exposure falls by 1 unless it is at the minimum. Only in that case does gain fall by 1, saturating at 0.
- R7: With `area_center` = 1, only pixels at column c and row r with COLS/4 ≤ c < COLS−COLS/4 and ROWS/4 ≤ r < ROWS−ROWS/4 are counted. Rows and columns are numbered from 0, starting at the first `line_start` of the frame and the first valid pixel of the line.
- R8: While `ae_freeze` = 1 at frame end, neither exposure nor gain changes.
- R9: While `exp_hold` = 1 at frame end, exposure does not change, and any up or down step is applied to gain instead.
- R10: The minimum exposure is 1, or 4 when `min_exp4` = 1. If exposure is below the minimum at an unfrozen, unheld frame end, it is set to the minimum and no other step is taken that frame. Exposure is never 0.
- R11: `ae_stable` is 1 after a frame end at which neither exposure nor gain changed, and 0 after one at which either changed. It keeps its value between frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle strobe before the first line of a frame |
| line_start | input | 1 | One-cycle strobe before each line's pixels |
| frame_end | input | 1 | One-cycle strobe after the last pixel of a frame |
| pix_valid | input | 1 | Pixel qualifier |
| pix_luma | input | PIX_W | Pixel luma |
| bright_lvl | input | PIX_W | Bright threshold level |
| dark_lvl | input | PIX_W | Dark threshold level |
| bright_tgt | input | 8 | Bright fraction target |
| black_tgt | input | 8 | Dark fraction target |
| area_center | input | 1 | 1: count the central quarter only |
| ae_freeze | input | 1 | Hold exposure and gain |
| exp_hold | input | 1 | Hold exposure only |
| min_exp4 | input | 1 | Minimum exposure of 4 instead of 1 |
| exposure | output | 8 | Exposure register in lines |
| gain | output | GAIN_W | Gain register |
| ae_stable | output | 1 | Last update left both registers unchanged |

## Verification
The bench builds the block for an 8×8 image, with a 2-bit gain and an initial exposure of 250. Exposure therefore reaches its top within five dark frames, and gain saturates three frames later. The full walk down to the one-line floor, with gain draining after it, fits in a few hundred short frames. The 8×8 image also makes the central quarter exactly 16 pixels, so a pattern can put the whole-frame and centre-only decisions on opposite sides of both targets.

// File: rtl/ae_pkg.sv
package ae_pkg;
   typedef enum logic [1:0] {
      AE_HOLD = 2'd0,
      AE_UP   = 2'd1,
      AE_DOWN = 2'd2
   } ae_dir_t;
endpackage

// File: rtl/ae_window.sv
module ae_window #(
   parameter int COLS = 352,
   parameter int ROWS = 288
) (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_start,
   input  logic line_start,
   input  logic pix_valid,
   input  logic area_center,
   output logic in_win
);
   localparam int COL_W  = $clog2(COLS + 1);
   localparam int ROW_W  = $clog2(ROWS + 1);
   localparam int COL_LO = COLS / 4;
   localparam int COL_HI = COLS - COLS / 4;
   localparam int ROW_LO = ROWS / 4;
   localparam int ROW_HI = ROWS - ROWS / 4;

   if (COLS < 4 || ROWS < 4) begin : g_bad_size
      $error("ae_window: image must be at least 4x4");
   end

   logic [COL_W-1:0] col_q;
   logic [ROW_W-1:0] row_q;
   logic             seen_q;
   logic             center_hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         col_q  <= '0;
         row_q  <= '0;
         seen_q <= 1'b0;
      end else begin
         if (frame_start) begin
            row_q  <= '0;
            seen_q <= 1'b0;
         end else if (line_start) begin
            if (seen_q) row_q <= row_q + 1'b1;
            seen_q <= 1'b1;
         end
         if (line_start)     col_q <= '0;
         else if (pix_valid) col_q <= col_q + 1'b1;
      end
   end

   assign center_hit = (col_q >= COL_W'(COL_LO)) && (col_q < COL_W'(COL_HI)) &&
                       (row_q >= ROW_W'(ROW_LO)) && (row_q < ROW_W'(ROW_HI));
   assign in_win = pix_valid && (!area_center || center_hit);

   AST_ROW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_start && !line_start) |=> $stable(row_q)) else $error("row moved"); // R7
endmodule

// File: rtl/ae_counters.sv
module ae_counters #(
   parameter int PIX_W = 8,
   parameter int CNT_W = 17
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_start,
   input  logic             in_win,
   input  logic [PIX_W-1:0] pix_luma,
   input  logic [PIX_W-1:0] bright_lvl,
   input  logic [PIX_W-1:0] dark_lvl,
   output logic [CNT_W-1:0] cnt_total,
   output logic [CNT_W-1:0] cnt_bright,
   output logic [CNT_W-1:0] cnt_dark
);
   localparam int NPOP = 2;

   if (CNT_W < 2) begin : g_bad_cnt
      $error("ae_counters: CNT_W too small");
   end

   logic [NPOP-1:0]  hit;
   logic [CNT_W-1:0] pop_q [NPOP];
   logic [CNT_W-1:0] tot_q;

   assign hit[0] = pix_luma > bright_lvl;
   assign hit[1] = pix_luma < dark_lvl;

   always_ff @(posedge clk) begin
      if (!rst_n || frame_start) tot_q <= '0;
      else if (in_win)           tot_q <= tot_q + 1'b1;
   end

   for (genvar g = 0; g < NPOP; g++) begin : g_pop
      always_ff @(posedge clk) begin
         if (!rst_n || frame_start)  pop_q[g] <= '0;
         else if (in_win && hit[g])  pop_q[g] <= pop_q[g] + 1'b1;
      end

      AST_POP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
         pop_q[g] <= tot_q) else $error("population above total"); // R2
   end

   AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> (tot_q == '0)) else $error("total not cleared"); // R3

   assign cnt_total  = tot_q;
   assign cnt_bright = pop_q[0];
   assign cnt_dark   = pop_q[1];
endmodule

// File: rtl/ae_step.sv
module ae_step
   import ae_pkg::*;
#(
   parameter int          CNT_W         = 17,
   parameter int          EXP_W         = 8,
   parameter int          GAIN_W        = 6,
   parameter int          TGT_DEN       = 202,
   parameter logic [7:0]  EXP_INIT      = 8'h40,
   parameter int          EXP_MIN_SHORT = 1,
   parameter int          EXP_MIN_LONG  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_end,
   input  logic [CNT_W-1:0]  cnt_total,
   input  logic [CNT_W-1:0]  cnt_bright,
   input  logic [CNT_W-1:0]  cnt_dark,
   input  logic [7:0]        bright_tgt,
   input  logic [7:0]        black_tgt,
   input  logic              ae_freeze,
   input  logic              exp_hold,
   input  logic              min_exp4,
   output logic [EXP_W-1:0]  exposure,
   output logic [GAIN_W-1:0] gain,
   output logic              ae_stable
);
   localparam int                PROD_W   = CNT_W + 8;
   localparam logic [EXP_W-1:0]  EXP_MAX  = '1;
   localparam logic [GAIN_W-1:0] GAIN_MAX = '1;

   if (TGT_DEN < 1 || TGT_DEN > 255) begin : g_bad_den
      $error("ae_step: TGT_DEN out of range");
   end
   if (EXP_INIT == 0 || EXP_MIN_SHORT < 1 || EXP_MIN_LONG < EXP_MIN_SHORT) begin : g_bad_min
      $error("ae_step: exposure limits inconsistent");
   end

   logic [PROD_W-1:0] b_meas, d_meas, b_goal, d_goal;
   logic [EXP_W-1:0]  exp_q, exp_n, exp_min;
   logic [GAIN_W-1:0] gain_q, gain_n;
   logic              stb_q;
   ae_dir_t           dir;

   assign b_meas = PROD_W'(cnt_bright) * PROD_W'(TGT_DEN);
   assign d_meas = PROD_W'(cnt_dark)   * PROD_W'(TGT_DEN);
   assign b_goal = PROD_W'(bright_tgt) * PROD_W'(cnt_total);
   assign d_goal = PROD_W'(black_tgt)  * PROD_W'(cnt_total);

   always_comb begin
      if (b_meas < b_goal && d_meas > d_goal)      dir = AE_UP;
      else if (b_meas > b_goal && d_meas < d_goal) dir = AE_DOWN;
      else                                         dir = AE_HOLD;
   end

   assign exp_min = min_exp4 ? EXP_W'(EXP_MIN_LONG) : EXP_W'(EXP_MIN_SHORT);

   always_comb begin
      exp_n  = exp_q;
      gain_n = gain_q;
      if (!ae_freeze) begin
         if (!exp_hold && exp_q < exp_min) begin
            exp_n = exp_min;
         end else if (dir == AE_UP) begin
            if (!exp_hold && exp_q != EXP_MAX) exp_n  = exp_q + 1'b1;
            else if (gain_q != GAIN_MAX)       gain_n = gain_q + 1'b1;
         end else if (dir == AE_DOWN) begin
            if (!exp_hold && exp_q > exp_min)  exp_n  = exp_q - 1'b1;
            else if (gain_q != '0)             gain_n = gain_q - 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         exp_q  <= EXP_W'(EXP_INIT);
         gain_q <= '0;
         stb_q  <= 1'b0;
      end else if (frame_end) begin
         exp_q  <= exp_n;
         gain_q <= gain_n;
         stb_q  <= (exp_n == exp_q) && (gain_n == gain_q);
      end
   end

   assign exposure  = exp_q;
   assign gain      = gain_q;
   assign ae_stable = stb_q;

   AST_ONLY_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_end |=> ($stable(exp_q) && $stable(gain_q) && $stable(stb_q))) else $error("update off frame end"); // R5
   AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end && ae_freeze) |=> ($stable(exp_q) && $stable(gain_q))) else $error("freeze broken"); // R8
   AST_EXP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end && exp_hold) |=> $stable(exp_q)) else $error("exposure hold broken"); // R9
   AST_GAIN_AFTER_EXP: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end && !ae_freeze && !exp_hold && exp_q > exp_min && exp_q != EXP_MAX)
      |=> $stable(gain_q)) else $error("gain moved early"); // R6
   AST_EXP_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      exp_q != '0) else $error("exposure zero"); // R10
   AST_STABLE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |=> (stb_q == ($stable(exp_q) && $stable(gain_q)))) else $error("stable flag wrong"); // R11
endmodule

// File: rtl/ae_stats_ctrl.sv
module ae_stats_ctrl #(
   parameter int         PIX_W         = 8,
   parameter int         COLS          = 352,
   parameter int         ROWS          = 288,
   parameter int         GAIN_W        = 6,
   parameter int         TGT_DEN       = 202,
   parameter logic [7:0] EXP_INIT      = 8'h40,
   parameter int         EXP_MIN_SHORT = 1,
   parameter int         EXP_MIN_LONG  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              line_start,
   input  logic              frame_end,
   input  logic              pix_valid,
   input  logic [PIX_W-1:0]  pix_luma,
   input  logic [PIX_W-1:0]  bright_lvl,
   input  logic [PIX_W-1:0]  dark_lvl,
   input  logic [7:0]        bright_tgt,
   input  logic [7:0]        black_tgt,
   input  logic              area_center,
   input  logic              ae_freeze,
   input  logic              exp_hold,
   input  logic              min_exp4,
   output logic [7:0]        exposure,
   output logic [GAIN_W-1:0] gain,
   output logic              ae_stable
);
   localparam int CNT_W = $clog2(COLS * ROWS + 1);

   if (GAIN_W < 1 || GAIN_W > 16) begin : g_bad_gain
      $error("ae_stats_ctrl: GAIN_W out of range");
   end

   logic             in_win;
   logic [CNT_W-1:0] cnt_total, cnt_bright, cnt_dark;

   ae_window #(.COLS(COLS), .ROWS(ROWS)) u_win (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_start(line_start),
      .pix_valid(pix_valid), .area_center(area_center), .in_win(in_win));

   ae_counters #(.PIX_W(PIX_W), .CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .in_win(in_win),
      .pix_luma(pix_luma), .bright_lvl(bright_lvl), .dark_lvl(dark_lvl),
      .cnt_total(cnt_total), .cnt_bright(cnt_bright), .cnt_dark(cnt_dark));

   ae_step #(.CNT_W(CNT_W), .EXP_W(8), .GAIN_W(GAIN_W), .TGT_DEN(TGT_DEN),
             .EXP_INIT(EXP_INIT), .EXP_MIN_SHORT(EXP_MIN_SHORT),
             .EXP_MIN_LONG(EXP_MIN_LONG)) u_step (
      .clk(clk), .rst_n(rst_n), .frame_end(frame_end),
      .cnt_total(cnt_total), .cnt_bright(cnt_bright), .cnt_dark(cnt_dark),
      .bright_tgt(bright_tgt), .black_tgt(black_tgt),
      .ae_freeze(ae_freeze), .exp_hold(exp_hold), .min_exp4(min_exp4),
      .exposure(exposure), .gain(gain), .ae_stable(ae_stable));
endmodule

// File: tb/tb_ae_stats_ctrl.sv
module tb_ae_stats_ctrl;
   localparam int GW   = 2;
   localparam int GMAX = 3;
   localparam int NC   = 8;
   localparam int NR   = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          frame_start = 0, line_start = 0, frame_end = 0, pix_valid = 0;
   logic [7:0]    pix_luma = 0;
   logic [7:0]    bright_lvl = 8'd200, dark_lvl = 8'd50;
   logic [7:0]    bright_tgt = 8'h33, black_tgt = 8'h97;
   logic          area_center = 0, ae_freeze = 0, exp_hold = 0, min_exp4 = 0;
   logic [7:0]    exposure;
   logic [GW-1:0] gain;
   logic          ae_stable;

   int n_chk = 0, n_bad = 0, cyc = 0;
   int m_exp = 250, m_gain = 0, m_stb = 0;
   bit done = 0;

   always #2 clk = ~clk;

   ae_stats_ctrl #(.COLS(NC), .ROWS(NR), .GAIN_W(GW), .EXP_INIT(8'd250)) dut (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_start(line_start),
      .frame_end(frame_end), .pix_valid(pix_valid), .pix_luma(pix_luma),
      .bright_lvl(bright_lvl), .dark_lvl(dark_lvl), .bright_tgt(bright_tgt),
      .black_tgt(black_tgt), .area_center(area_center), .ae_freeze(ae_freeze),
      .exp_hold(exp_hold), .min_exp4(min_exp4), .exposure(exposure), .gain(gain),
      .ae_stable(ae_stable));

   task automatic chk(input int act, input int exp_v, input string tag);
      n_chk++;
      if (act != exp_v) begin
         n_bad++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp_v);
      end
   endtask

   // mode 0: uniform lv; 1: checkerboard 230/10; 2: centre quarter 230, rest 10
   function automatic logic [7:0] pix(input int mode, input int lv, input int r, input int c);
      if (mode == 0) return lv[7:0];
      if (mode == 1) return ((r + c) % 2 == 0) ? 8'd230 : 8'd10;
      return (r >= 2 && r < 6 && c >= 2 && c < 6) ? 8'd230 : 8'd10;
   endfunction

   // model of R6/R8/R9/R10/R11; dir: 1 up, -1 down, 0 hold
   task automatic model_step(input int dir);
      int oe = m_exp, og = m_gain;
      int mn = min_exp4 ? 4 : 1;
      if (!ae_freeze) begin
         if (!exp_hold && m_exp < mn) m_exp = mn;
         else if (dir > 0) begin
            if (!exp_hold && m_exp < 255) m_exp++;
            else if (m_gain < GMAX) m_gain++;
         end else if (dir < 0) begin
            if (!exp_hold && m_exp > mn) m_exp--;
            else if (m_gain > 0) m_gain--;
         end
      end
      m_stb = (oe == m_exp && og == m_gain) ? 1 : 0;
   endtask

   task automatic run_frame(input int mode, input int lv, input int dir, input string tag);
      @(negedge clk) frame_start = 1;
      @(negedge clk) frame_start = 0;
      for (int r = 0; r < NR; r++) begin
         line_start = 1;
         @(negedge clk) line_start = 0;
         for (int c = 0; c < NC; c++) begin
            pix_valid = 1; pix_luma = pix(mode, lv, r, c);
            @(negedge clk);
         end
         pix_valid = 0;
      end
      chk(exposure, m_exp, {tag, " R5 pre"});
      frame_end = 1;
      @(negedge clk) frame_end = 0;
      model_step(dir);
      chk(exposure, m_exp, {tag, " exposure"});
      chk(gain, m_gain, {tag, " gain"});
      chk(ae_stable, m_stb, {tag, " R11 stable"});
   endtask

   task automatic t_reset;
      chk(exposure, 250, "R1 exposure");
      chk(gain, 0, "R1 gain");
      chk(ae_stable, 0, "R1 stable");
   endtask

   task automatic t_up_sat;
      for (int i = 0; i < 9; i++) run_frame(0, 10, 1, "R6 up");
      chk(exposure, 255, "R6 exp max");
      chk(gain, GMAX, "R6 gain max");
      chk(ae_stable, 1, "R11 saturated");
   endtask

   task automatic t_clear;
      run_frame(0, 250, -1, "R3 bright");
      run_frame(0, 100, 0, "R3 neutral after bright");
   endtask

   task automatic t_down;
      while (m_exp > 1 || m_gain > 0) run_frame(0, 250, -1, "R6 down");
      run_frame(0, 250, -1, "R10 floor");
      chk(exposure, 1, "R10 min one");
      chk(gain, 0, "R6 gain zero");
   endtask

   task automatic t_min4;
      min_exp4 = 1;
      run_frame(0, 100, 0, "R10 clamp");
      chk(exposure, 4, "R10 clamp to four");
      run_frame(0, 250, -1, "R10 floor4");
      min_exp4 = 0;
   endtask

   task automatic t_thresh;
      run_frame(0, 200, 0, "R2 equal bright lvl");
      run_frame(0, 201, -1, "R2 above bright lvl");
      run_frame(0, 50, 0, "R2 equal dark lvl");
      run_frame(0, 49, 1, "R2 below dark lvl");
   endtask

   task automatic t_center;
      area_center = 0;
      run_frame(2, 0, 1, "R7 whole frame");
      area_center = 1;
      run_frame(2, 0, -1, "R7 centre quarter");
      area_center = 0;
   endtask

   task automatic t_targets;
      run_frame(1, 0, -1, "R4 default targets");
      bright_tgt = 8'hCA;
      run_frame(1, 0, 0, "R4 high bright target");
      black_tgt = 8'h01;
      run_frame(1, 0, 1, "R4 low black target");
      bright_tgt = 8'h33; black_tgt = 8'h97;
   endtask

   task automatic t_freeze;
      ae_freeze = 1;
      run_frame(0, 10, 1, "R8 freeze");
      ae_freeze = 0;
   endtask

   task automatic t_hold;
      exp_hold = 1;
      run_frame(0, 10, 1, "R9 hold up");
      chk(gain, 1, "R9 gain took step");
      run_frame(0, 250, -1, "R9 hold down");
      exp_hold = 0;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 200000 && !done) begin
         done = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog act=%0d exp=%0d", cyc, 200000);
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset;
      t_up_sat;
      t_clear;
      t_down;
      t_min4;
      t_thresh;
      t_center;
      t_targets;
      t_freeze;
      t_hold;
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule